// File: doc/BRIEF.md
# Multi-Polynomial Byte-Stream CRC Engine

This block folds a byte stream into a running CRC, one byte per clock. A two-bit type field in its mode register selects the polynomial. Three are supported: the 32-bit Ethernet CRC (0x04C11DB7), the 32-bit Castagnoli CRC (0x1EDC6F41) and the 16-bit CCITT CRC (0x1021). Software configures the engine and reads the result over a simple word-addressed register bus. Writes complete in the clock cycle they are presented. Reads are combinational from the address.

In the 32-bit modes the result register holds a raw value. Software obtains the standard CRC by reversing the bit order of all 32 bits and then complementing the word. In the 16-bit mode the CRC is the low half of the result register, with no further processing. Writing the control register restarts the accumulator.

An error is flagged when the stream offers a byte while the engine is disabled. The error raises an interrupt through write-1-to-set and write-1-to-clear enable registers, a readable mask and a status bit. The compare bit and the four-bit divider field are only stored and read back.

Top module: `crc_engine`

## Requirements
- R1: After `rst_n` is released, the result reads 0xFFFFFFFF, the mode reads 0, the mask and status read 0, and `in_ready` and `irq` are 0.
- R2: With type 0 (mode bits 3:2 = 00), the bit-reversed, complemented result equals the standard CRC-32 of the bytes absorbed since the last restart. For ASCII "123456789" this value is 0xCBF43926.
- R3: With type 1 (bits 3:2 = 01), the same transform gives the standard CRC-32C. For "123456789" this value is 0xE3069283.
- R4: With type 2 or 3 (bit 3 = 1), the result low 16 bits are the CCITT CRC (polynomial 0x1021, data fed MSB first, start value 0xFFFF, no final XOR). For "123456789" this value is 0x29B1. The result high 16 bits read 0.
- R5: `in_ready` equals mode bit 0 (enable). A byte is absorbed on every clock edge at which `in_valid` and `in_ready` are both 1, so back-to-back bytes are absorbed one per clock.
- R6: While enable is 0, the result register keeps its value and offered bytes are not absorbed.
- R7: Writing bus data bit 0 = 1 to offset 0 (control) loads the start value: 0xFFFFFFFF for types 0 and 1, and 0x0000FFFF for types 2 and 3. A control write with bit 0 = 0 has no effect. A restart in the same cycle as an absorbed byte wins, and the byte is lost.
- R8: Offset 1 (mode) reads back bits 7:0 exactly as written: bit 0 enable, bit 1 compare, bits 3:2 type, bits 7:4 divider. The compare bit and the divider do not change the CRC.
- R9: A cycle with `in_valid` = 1 and enable = 0 sets the error status (offset 6, bit 0). A restart clears the status. A new error event in the same cycle as a restart leaves the status set.
- R10: Writing bit 0 = 1 to offset 3 sets the mask (offset 5, bit 0), and writing bit 0 = 1 to offset 4 clears it. `irq` is 1 exactly when the mask and the status are both 1.
- R11: Offsets 0, 3 and 4, and unused offset 7, read 0. Offset 2 is the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 8 | Write data (all writable fields lie in bits 7:0) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| in_valid | input | 1 | Stream byte offered |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Engine is accepting bytes |
| irq | output | 1 | Error interrupt |

## Verification
Two things can land on the same clock edge:
- a restart write and a byte handshake, which both update the accumulator;
- a restart write and an error event, which both update the status bit.

The bench drives each pair together from one negative edge. For the first pair, it reads 0xFFFFFFFF right afterwards. It then confirms that a full "123456789" run still yields 0xCBF43926, which proves the colliding byte left no trace. For the second pair, the status must read 1 after the restart.

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter logic [31:0] RPOLY_ETH  = 32'hEDB88320,
  parameter logic [31:0] RPOLY_CAST = 32'h82F63B78,
  parameter logic [15:0] POLY_CCITT = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        irq
);

  logic [7:0]  mode_q;
  logic [31:0] acc_q;
  logic [31:0] acc_step;
  logic [31:0] acc_rev;
  logic        mask_q;
  logic        stat_q;

  wire enable  = mode_q[0];
  wire narrow  = mode_q[3];
  wire [31:0] rpoly = mode_q[2] ? RPOLY_CAST : RPOLY_ETH;
  wire [31:0] start_val = narrow ? 32'h0000FFFF : 32'hFFFFFFFF;

  wire take    = in_valid & enable;
  wire err_evt = in_valid & ~enable;
  wire restart = bus_wr && bus_addr == 3'd0 && bus_wdata[0];
  wire wr_mode = bus_wr && bus_addr == 3'd1;
  wire wr_ien  = bus_wr && bus_addr == 3'd3 && bus_wdata[0];
  wire wr_idis = bus_wr && bus_addr == 3'd4 && bus_wdata[0];

  assign in_ready = enable;
  assign irq      = mask_q & stat_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] s_in, input logic [7:0] d,
                                           input logic nar, input logic [31:0] rp);
    logic [31:0] s;
    logic        fb;
    s = s_in;
    for (int i = 0; i < 8; i++) begin
      if (nar) begin
        fb = s[15] ^ d[7-i];
        s  = {16'h0, s[14:0], 1'b0} ^ (fb ? {16'h0, POLY_CCITT} : 32'h0);
      end else begin
        fb = s[0] ^ d[i];
        s  = (s >> 1) ^ (fb ? rp : 32'h0);
      end
    end
    return s;
  endfunction

  always_comb acc_step = crc_byte(acc_q, in_data, narrow, rpoly);

  always_comb
    for (int i = 0; i < 32; i++) acc_rev[i] = acc_q[31-i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'h00;
      acc_q  <= 32'hFFFFFFFF;
      mask_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (restart)   acc_q <= start_val;
      else if (take) acc_q <= acc_step;
      if (wr_ien)       mask_q <= 1'b1;
      else if (wr_idis) mask_q <= 1'b0;
      stat_q <= (stat_q & ~restart) | err_evt;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd1:    bus_rdata = {24'h0, mode_q};
      3'd2:    bus_rdata = narrow ? {16'h0, acc_q[15:0]} : acc_rev;
      3'd5:    bus_rdata = {31'h0, mask_q};
      3'd6:    bus_rdata = {31'h0, stat_q};
      default: bus_rdata = 32'h0;
    endcase
  end

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !restart) |=> $stable(acc_q));
  assert_restart_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == ($past(narrow) ? 32'h0000FFFF : 32'hFFFFFFFF)));
  assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && narrow && !restart) |=> (acc_q[31:16] == 16'h0));
  assert_err_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> stat_q);
  assert_disable_quiets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idis |=> !irq);

endmodule

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [31:0] bus_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_ready;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] msg [16];

  crc_engine u_crc_engine (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] ref32(input logic [31:0] rp, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      c ^= {24'h0, msg[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [15:0] ref16(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c ^= {msg[k], 8'h0};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic stream(input int n);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_data = msg[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic load_digits();
    for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); check("R1 result", v, 32'hFFFFFFFF);
    rd(3'd1, v); check("R1 mode", v, 0);
    rd(3'd5, v); check("R1 mask", v, 0);
    rd(3'd6, v); check("R1 status", v, 0);
    check("R1 in_ready", {31'h0, in_ready}, 0);
    check("R1 irq", {31'h0, irq}, 0);
    rd(3'd0, v); check("R11 ctrl reads 0", v, 0);
    rd(3'd7, v); check("R11 unused reads 0", v, 0);
  endtask

  task automatic t_string(input logic [7:0] mode, input string req, input logic [31:0] exp);
    logic [31:0] v;
    wr(3'd1, mode);
    wr(3'd0, 8'h01);
    load_digits();
    stream(9);
    rd(3'd2, v);
    if (mode[3]) begin
      check({req, " ccitt low"}, {16'h0, v[15:0]}, exp);
      check({req, " ccitt high zero"}, {16'h0, v[31:16]}, 0);
    end else
      check(req, ~rev32(v), exp);
  endtask

  task automatic t_pattern();
    logic [31:0] v;
    for (int k = 0; k < 16; k++) msg[k] = 8'(k * 37 + 5);
    wr(3'd1, 8'h01);
    check("R5 ready follows enable", {31'h0, in_ready}, 1);
    wr(3'd0, 8'h01);
    stream(16);
    rd(3'd2, v); check("R5 back-to-back crc32", ~rev32(v), ref32(32'hEDB88320, 16));
    wr(3'd1, 8'h05); wr(3'd0, 8'h01);
    stream(16);
    rd(3'd2, v); check("R3 pattern crc32c", ~rev32(v), ref32(32'h82F63B78, 16));
    wr(3'd1, 8'h09); wr(3'd0, 8'h01);
    stream(16);
    rd(3'd2, v); check("R4 pattern ccitt", v, {16'h0, ref16(16)});
  endtask

  task automatic t_mode_rb();
    logic [31:0] v;
    wr(3'd1, 8'hA6);
    rd(3'd1, v); check("R8 mode readback", v, 32'hA6);
    t_string(8'hF7, "R8 compare/divider no effect", 32'hE3069283);
  endtask

  task automatic t_hold();
    logic [31:0] held, v;
    wr(3'd1, 8'h01); wr(3'd0, 8'h01);
    load_digits();
    stream(4);
    wr(3'd1, 8'h00);
    rd(3'd2, held);
    rd(3'd6, v); check("R9 status clear before", v, 0);
    check("R5 ready low when disabled", {31'h0, in_ready}, 0);
    stream(3);
    rd(3'd2, v); check("R6 result held", v, held);
    check("R6 held value is 4-byte crc", ~rev32(v), ref32(32'hEDB88320, 4));
    rd(3'd6, v); check("R9 status set", v, 1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    check("R10 irq masked", {31'h0, irq}, 0);
    wr(3'd3, 8'h01);
    rd(3'd5, v); check("R10 mask set", v, 1);
    check("R10 irq raised", {31'h0, irq}, 1);
    rd(3'd3, v); check("R11 enable reg reads 0", v, 0);
    wr(3'd4, 8'h01);
    rd(3'd5, v); check("R10 mask cleared", v, 0);
    check("R10 irq dropped", {31'h0, irq}, 0);
    rd(3'd4, v); check("R11 disable reg reads 0", v, 0);
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h01);
    rd(3'd6, v); check("R9 restart clears status", v, 0);
    check("R10 irq after clear", {31'h0, irq}, 0);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(3'd1, 8'h01);
    load_digits();
    stream(3);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h01;
    in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk);
    bus_wr = 1'b0; in_valid = 1'b0;
    rd(3'd2, v); check("R7 restart beats byte", v, 32'hFFFFFFFF);
    stream(9);
    rd(3'd2, v); check("R2 after collision", ~rev32(v), 32'hCBF43926);
    wr(3'd0, 8'h00);
    rd(3'd2, v); check("R7 ctrl bit0=0 no effect", ~rev32(v), 32'hCBF43926);
    wr(3'd1, 8'h0B); wr(3'd0, 8'h01);
    rd(3'd2, v); check("R7 narrow start value", v, 32'h0000FFFF);
    wr(3'd1, 8'h00);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h01; in_valid = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; in_valid = 1'b0;
    rd(3'd6, v); check("R9 event beats restart", v, 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_string(8'h01, "R2 crc32 check value", 32'hCBF43926);
    t_string(8'h05, "R3 crc32c check value", 32'hE3069283);
    t_string(8'h09, "R4 type2", 32'h000029B1);
    t_string(8'h0D, "R4 type3", 32'h000029B1);
    t_pattern();
    t_mode_rb();
    t_hold();
    t_irq();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule